// File: doc/BRIEF.md
# Fault-Latching Input Gate Controller

This block is the input-side control logic of an isolated power-switch gate driver. Two command inputs, one non-inverting and one inverting, decide whether the switch should be on. The result is registered into a drive request, which enables the emitter that carries the command across the isolation barrier.

A fault indication comes back from the isolated output side. When it arrives, the controller latches it. While the fault is latched, the drive request is forced off, the command inputs are ignored, and an open-drain fault flag is pulled low. The open-drain flag is modelled as a pull-low enable.

A separate active-low clear input releases the latch, but only once the returning fault has gone away. While no fault is latched, the clear input does nothing. Both the returning fault and the clear input are asynchronous, so each passes through a two-flop synchronizer before it is used.

Top module: `fault_gate_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycles after it, `flag_pull` is 0 and `drive_req` is 0.
- R2: With no fault latched, `drive_req` equals `cmd_pos & ~cmd_neg` as sampled at the previous rising clock edge. All four input combinations are covered: only 1/0 gives 1.
- R3: With no fault latched, `flag_pull` is 0, meaning the flag pin is released.
- R4: With no fault latched and `flt_in` low, driving `clr_n` low changes neither `flag_pull` nor `drive_req`.
- R5: After `flt_in` goes high, `flag_pull` becomes 1 on the third rising edge (two synchronizer stages plus the latch). On that same edge `drive_req` becomes 0. On the second edge neither output has changed yet.
- R6: While the fault is latched and `clr_n` stays high, `flag_pull` stays 1 and `drive_req` stays 0. This holds after `flt_in` returns low and whatever the command inputs do.
- R7: The latch clears on the first rising edge at which both the synchronized clear and the synchronized fault are low. At the ports, this is the third edge after the later of `clr_n` falling and `flt_in` falling.
- R8: While `flt_in` is still high, holding `clr_n` low does not clear the latch.
- R9: On the edge where the latch clears, `drive_req` again takes `cmd_pos & ~cmd_neg` from that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cmd_pos | input | 1 | Non-inverting command input |
| cmd_neg | input | 1 | Inverting command input |
| clr_n | input | 1 | Active-low fault clear, asynchronous |
| flt_in | input | 1 | Fault indication from the isolated side, active high, asynchronous |
| drive_req | output | 1 | Request to enable the barrier emitter |
| flag_pull | output | 1 | 1 pulls the open-drain active-low fault flag low |

## Verification
The assertions assume that `flt_in` and `clr_n` reach the latch only through a fixed three-edge path. For that reason they compare the latch state only with input values from at least four edges after reset release. They also assume the command inputs are stable around each edge.

The bench respects these assumptions:
- It changes every input on the falling edge.
- It holds each fault and clear level for at least three cycles before checking the result.
- It keeps all inputs inactive while reset is applied.

// File: rtl/fault_gate_ctrl.sv
module fault_gate_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic cmd_pos,
  input  logic cmd_neg,
  input  logic clr_n,
  input  logic flt_in,
  output logic drive_req,
  output logic flag_pull
);

  logic [1:0] flt_sync;
  logic [1:0] clr_sync;
  logic       fault_q;
  logic       drv_q;
  logic       latch_d;

  // set by a synchronized fault; held unless the synchronized clear is low
  assign latch_d = flt_sync[1] | (fault_q & clr_sync[1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_sync <= 2'b00;
      clr_sync <= 2'b11;
      fault_q  <= 1'b0;
      drv_q    <= 1'b0;
    end else begin
      flt_sync <= {flt_sync[0], flt_in};
      clr_sync <= {clr_sync[0], clr_n};
      fault_q  <= latch_d;
      drv_q    <= ~latch_d & cmd_pos & ~cmd_neg;
    end
  end

  assign drive_req = drv_q;
  assign flag_pull = fault_q;

endmodule

// File: rtl/fault_gate_chk.sv
module fault_gate_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_pos,
  input logic cmd_neg,
  input logic clr_n,
  input logic flt_in,
  input logic drive_req,
  input logic flag_pull
);

  logic [2:0] warm;
  logic       ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warm <= 3'd0;
    else if (warm != 3'd4) warm <= warm + 3'd1;
  end

  assign ok = (warm == 3'd4);

  p_off_when_latched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flag_pull |-> !drive_req);

  p_cmd_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !flag_pull) |-> (drive_req == $past(cmd_pos && !cmd_neg)));

  p_latch_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && $past(flt_in, 3)) |-> flag_pull);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && $past(flag_pull) && $past(clr_n, 3)) |-> flag_pull);

  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !$past(flt_in, 3) && !$past(clr_n, 3)) |-> !flag_pull);

  p_no_spurious_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && !$past(flag_pull) && !$past(flt_in, 3)) |-> !flag_pull);

  always_comb begin
    if (!rst_n) p_reset_r1: assert (!flag_pull && !drive_req);
  end

endmodule

bind fault_gate_ctrl fault_gate_chk u_chk (.*);

// File: tb/sim_fault_gate_ctrl.sv
`timescale 1ns/1ps
module sim_fault_gate_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_pos = 1'b0, cmd_neg = 1'b0, clr_n = 1'b1, flt_in = 1'b0;
  logic drive_req, flag_pull;
  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  fault_gate_ctrl u0 (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    step(2);
    chk("R1 flag in reset", flag_pull, 1'b0);
    chk("R1 drive in reset", drive_req, 1'b0);
    rst_n = 1'b1;
    step(2);
    chk("R1 flag after reset", flag_pull, 1'b0);
    chk("R1 drive after reset", drive_req, 1'b0);
  endtask

  task automatic t_cmd();
    for (int i = 0; i < 4; i++) begin
      cmd_pos = i[0];
      cmd_neg = i[1];
      step(1);
      chk($sformatf("R2 cmd combo %0d", i), drive_req, i[0] & ~i[1]);
      chk("R3 flag released", flag_pull, 1'b0);
    end
  endtask

  task automatic t_clr_idle();
    cmd_pos = 1'b1; cmd_neg = 1'b0;
    clr_n = 1'b0;
    step(5);
    chk("R4 clear idle flag", flag_pull, 1'b0);
    chk("R4 clear idle drive", drive_req, 1'b1);
    clr_n = 1'b1;
    step(3);
  endtask

  task automatic t_latch();
    flt_in = 1'b1;
    step(2);
    chk("R5 not yet latched", flag_pull, 1'b0);
    chk("R5 drive still on", drive_req, 1'b1);
    step(1);
    chk("R5 latched", flag_pull, 1'b1);
    chk("R5 drive forced off", drive_req, 1'b0);
  endtask

  task automatic t_hold();
    flt_in = 1'b0;
    cmd_pos = 1'b1; cmd_neg = 1'b0;
    step(6);
    chk("R6 holds after fault gone", flag_pull, 1'b1);
    chk("R6 cmd ignored", drive_req, 1'b0);
    cmd_pos = 1'b0;
    step(1);
    cmd_pos = 1'b1;
    step(1);
    chk("R6 cmd toggle ignored", drive_req, 1'b0);
  endtask

  task automatic t_clear();
    clr_n = 1'b0;
    step(2);
    chk("R7 not yet cleared", flag_pull, 1'b1);
    step(1);
    chk("R7 cleared", flag_pull, 1'b0);
    chk("R9 drive resumes", drive_req, 1'b1);
    clr_n = 1'b1;
    step(3);
  endtask

  task automatic t_collide();
    flt_in = 1'b1;
    clr_n = 1'b0;
    step(8);
    chk("R8 fault present, clear low", flag_pull, 1'b1);
    chk("R8 drive off", drive_req, 1'b0);
    flt_in = 1'b0;
    step(2);
    chk("R7 waits for sync fault", flag_pull, 1'b1);
    step(1);
    chk("R7 cleared after fault drop", flag_pull, 1'b0);
    cmd_pos = 1'b0;
    step(1);
    chk("R9 follows cmd after clear", drive_req, 1'b0);
    clr_n = 1'b1;
    step(3);
  endtask

  initial begin
    t_reset();
    t_cmd();
    t_clr_idle();
    t_latch();
    t_hold();
    t_clear();
    t_collide();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule